// File: doc/BRIEF.md
# Processor I/O Port with Bank Control

This block is the two-register on-chip port of an 8-bit processor, placed at bus offsets 0 and 1. Offset 0 is a direction register: a 1 in a bit makes that port bit an output. Offset 1 is the port latch. A processor write to the latch changes only the bits currently marked as outputs. The three lowest latch bits leave the block as memory-banking selects for an external address decoder. These selects choose between ROM and RAM for the low ROM window at 0xA000 and the high ROM window at 0xE000, and they choose the character-ROM / IO window.

Reads return either the direction register or the latch. Latch bit 5 has a quirk: it reads back as 0 whenever its direction bit marks it as an input. Bus accesses are plain register accesses with no handshake. Every access is accepted in the cycle it is presented, so the block never applies back-pressure. Writes are captured on the rising clock edge when `cs` and `we` are both high. Read data is combinational from `addr`. Reset is synchronous and active-high.

Top module: `cpu_bank_port`

## Requirements
- R1: In the first cycle after reset, a read at offset 0 returns 0xEF, a read at offset 1 returns 0x37, and all three bank selects are 1.
- R2: A write with `cs`=1, `we`=1 and `addr`=0 loads `wdata` into the direction register. From the next cycle, a read at offset 0 returns that value unchanged.
- R3: A write with `cs`=1, `we`=1 and `addr`=1 sets the latch to (old AND NOT dir) OR (wdata AND dir).
- R4: While direction bit 5 is 0, a read at offset 1 returns the latch with bit 5 cleared.
- R5: While direction bit 5 is 1, a read at offset 1 returns the latch unmodified.
- R6: The selects follow latch bits directly, whatever the direction settings: `sel_lo_rom` follows bit 0, `sel_hi_rom` follows bit 1 and `sel_char_io` follows bit 2. Each select changes in the cycle after the write that alters it.
- R7: A cycle with `cs`=0 or `we`=0 changes neither register nor any select.
- R8: With every direction bit at 0, latch writes have no effect and the selects stay at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select from the external address decoder |
| we | input | 1 | Write enable, qualified by `cs` |
| addr | input | 1 | Register offset: 0 selects direction, 1 selects latch |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| sel_lo_rom | output | 1 | Low ROM window select (1 = ROM) |
| sel_hi_rom | output | 1 | High ROM window select (1 = ROM) |
| sel_char_io | output | 1 | Character-ROM / IO window select |

## Verification
A write is due one clock edge after it is presented. Both the register contents and the selects it alters appear just after the rising edge that captures it. The bench drives inputs on the falling edge and checks `rdata` and the selects at the next falling edge. Before that edge, it also samples the selects once to confirm that they have not moved early. Read data has no register on its path, so after `addr` changes the bench waits only a short settling delay within the same cycle before comparing.

// File: rtl/cpu_bank_port_pkg.sv
package cpu_bank_port_pkg;
  localparam int PORT_W = 8;
  localparam int SEL_N  = 3;
  typedef enum logic {
    REG_DIR  = 1'b0,
    REG_DATA = 1'b1
  } port_reg_e;
endpackage

// File: rtl/port_dir_reg.sv
module port_dir_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = 8'hEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (rst)        dir_q <= RST_VAL;
    else if (wr_en) dir_q <= wdata;
  end

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> dir_q == $past(wdata));
  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(dir_q));
endmodule

// File: rtl/port_data_latch.sv
module port_data_latch #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = 8'h37
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] dir,
  output logic [W-1:0] lat_q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                  lat_q[b] <= RST_VAL[b];
      else if (wr_en && dir[b]) lat_q[b] <= wdata[b];
    end
  end

  assert_input_bits_hold_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((lat_q ^ $past(lat_q)) & ~$past(dir)) == '0);
  assert_output_bits_take_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((lat_q ^ $past(wdata)) & $past(dir)) == '0);
  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(lat_q));
  assert_latch_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> lat_q == RST_VAL);
endmodule

// File: rtl/port_read_mux.sv
module port_read_mux #(
  parameter int W = 8,
  parameter int QUIRK_BIT = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         addr,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] lat,
  output logic [W-1:0] rdata
);
  import cpu_bank_port_pkg::*;
  localparam logic [W-1:0] QUIRK_MASK = W'(1) << QUIRK_BIT;

  logic [W-1:0] lat_view;

  always_comb begin
    lat_view = lat;
    if (!dir[QUIRK_BIT]) lat_view = lat & ~QUIRK_MASK;
  end

  always_comb begin
    if (addr == REG_DIR) rdata = dir;
    else                 rdata = lat_view;
  end

  assert_quirk_low_R4: assert property (@(posedge clk) disable iff (rst)
    (addr == REG_DATA && !dir[QUIRK_BIT]) |-> !rdata[QUIRK_BIT]);
  assert_quirk_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (addr == REG_DATA && dir[QUIRK_BIT]) |-> rdata == lat);
  assert_other_bits_R4: assert property (@(posedge clk) disable iff (rst)
    addr == REG_DATA |-> (rdata & ~QUIRK_MASK) == (lat & ~QUIRK_MASK));
endmodule

// File: rtl/cpu_bank_port.sv
module cpu_bank_port #(
  parameter int W = cpu_bank_port_pkg::PORT_W,
  parameter logic [W-1:0] DIR_RST  = 8'hEF,
  parameter logic [W-1:0] DATA_RST = 8'h37,
  parameter int QUIRK_BIT = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs,
  input  logic         we,
  input  logic         addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         sel_lo_rom,
  output logic         sel_hi_rom,
  output logic         sel_char_io
);
  import cpu_bank_port_pkg::*;

  logic         bus_wr;
  logic         dir_wr;
  logic         lat_wr;
  logic [W-1:0] dir_q;
  logic [W-1:0] lat_q;
  logic [SEL_N-1:0] sel_vec;

  assign bus_wr = cs && we;
  assign dir_wr = bus_wr && (addr == REG_DIR);
  assign lat_wr = bus_wr && (addr == REG_DATA);

  port_dir_reg #(.W(W), .RST_VAL(DIR_RST)) u_dir (
    .clk(clk), .rst(rst), .wr_en(dir_wr), .wdata(wdata), .dir_q(dir_q)
  );

  port_data_latch #(.W(W), .RST_VAL(DATA_RST)) u_lat (
    .clk(clk), .rst(rst), .wr_en(lat_wr), .wdata(wdata), .dir(dir_q), .lat_q(lat_q)
  );

  port_read_mux #(.W(W), .QUIRK_BIT(QUIRK_BIT)) u_rd (
    .clk(clk), .rst(rst), .addr(addr), .dir(dir_q), .lat(lat_q), .rdata(rdata)
  );

  assign sel_vec     = lat_q[SEL_N-1:0];
  assign sel_lo_rom  = sel_vec[0];
  assign sel_hi_rom  = sel_vec[1];
  assign sel_char_io = sel_vec[2];

  assert_sel_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable({sel_lo_rom, sel_hi_rom, sel_char_io}));
  assert_sel_no_dir_effect_R6: assert property (@(posedge clk) disable iff (rst)
    dir_wr |=> $stable({sel_lo_rom, sel_hi_rom, sel_char_io}));
  assert_all_input_R8: assert property (@(posedge clk) disable iff (rst)
    (lat_wr && dir_q == '0) |=> $stable({sel_lo_rom, sel_hi_rom, sel_char_io}));
  assert_reset_dir_R1: assert property (@(posedge clk)
    $fell(rst) |-> (addr != REG_DIR || rdata == DIR_RST));
endmodule

// File: tb/cpu_bank_port_bench.sv
module cpu_bank_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sel_lo_rom, sel_hi_rom, sel_char_io;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cpu_bank_port u_cpu_bank_port (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sel_lo_rom(sel_lo_rom), .sel_hi_rom(sel_hi_rom),
    .sel_char_io(sel_char_io)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic sels(input logic [2:0] exp, input string req);
    chk(req, {5'b0, sel_char_io, sel_hi_rom, sel_lo_rom}, {5'b0, exp});
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic c = 1'b1, input logic w = 1'b1);
    @(negedge clk);
    cs = c; we = w; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset;
    rd(1'b0, 8'hEF, "R1");
    rd(1'b1, 8'h37, "R1");
    sels(3'b111, "R1");
  endtask

  task automatic t_all_input;
    wr(1'b0, 8'h00);
    rd(1'b0, 8'h00, "R2");
    rd(1'b1, 8'h17, "R4");
    wr(1'b1, 8'h00);
    sels(3'b111, "R8");
    rd(1'b1, 8'h17, "R8");
  endtask

  task automatic t_quirk;
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'hFF);
    rd(1'b1, 8'hFF, "R5");
    wr(1'b0, 8'h00);
    rd(1'b1, 8'hDF, "R4");
    wr(1'b0, 8'hFF);
    rd(1'b1, 8'hFF, "R5");
  endtask

  task automatic t_masked;
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'hF0);
    wr(1'b0, 8'h20);
    wr(1'b1, 8'h55);
    rd(1'b1, 8'hD0, "R3");
    wr(1'b0, 8'h21);
    wr(1'b1, 8'h55);
    rd(1'b1, 8'hD1, "R3");
    wr(1'b0, 8'hC3);
    rd(1'b0, 8'hC3, "R2");
    wr(1'b1, 8'h20);
    rd(1'b1, 8'h10, "R3");
    wr(1'b1, 8'hFF);
    rd(1'b1, 8'hD3, "R3");
  endtask

  task automatic t_selects;
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h7F);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = 1'b1; wdata = 8'h7E;
    #1;
    sels(3'b111, "R6");
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    sels(3'b110, "R6");
    wr(1'b1, 8'h7D);
    sels(3'b101, "R6");
    wr(1'b1, 8'h7B);
    sels(3'b011, "R6");
    wr(1'b0, 8'h00);
    sels(3'b011, "R6");
  endtask

  task automatic t_no_access;
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h07);
    wr(1'b1, 8'h00, 1'b0, 1'b1);
    wr(1'b1, 8'h00, 1'b1, 1'b0);
    sels(3'b111, "R7");
    rd(1'b1, 8'h07, "R7");
    wr(1'b0, 8'h00, 1'b0, 1'b1);
    rd(1'b0, 8'hFF, "R7");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_all_input();
        t_quirk();
        t_masked();
        t_selects();
        t_no_access();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule